// File: doc/BRIEF.md
# Serial Bus Slave Acknowledge Generator

This block sits in the receive path of a slave node on a two-wire control bus for home appliances. A bit decoder upstream hands it received bits one at a time, along with a strobe at the start of each frame and a strobe naming each field as the field begins. For every field the block keeps an even-parity check. At the close of the slave-address, control, data-length and data fields it decides whether the node answers ACK or NAK.

The decision takes in parity, timing-error strobes and the node's own address. For the control field it also takes in the receive and transmit buffer flags, the lock state and the address of the master that holds the lock. When the block answers NAK it raises an abort flag. The flag holds, and the block ignores all input, until the next frame begins. In broadcast transfers no acknowledge is driven and no abort is raised.

Top module: `sbus_ack_gen`

## Requirements
- R1: After reset, `ack_valid`, `ack_nak` and `abort` are all 0.
- R2: Each field is followed by a parity bit that makes the count of ones even, so the parity bit is 1 when the field holds an odd number of ones. A mismatch gives NAK at the end of that field. A mismatch in the master-address field gives NAK at the end of the slave-address field.
- R3: `ack_valid` is high for exactly one cycle: the cycle after the parity bit is sampled. `ack_nak` is 0 for ACK and 1 for NAK, and it is 0 whenever `ack_valid` is low. An acknowledge follows only the slave-address (kind 1), control (kind 2), data-length (kind 3) and data (kind 4) fields, never the master-address field (kind 0).
- R4: At the end of the slave-address field the answer is NAK when the received address, sent MSB first, differs from `my_addr`.
- R5: A `timing_err` strobe gives NAK at the end of the field. It counts in any cycle from the one after `field_start` through the parity-bit cycle. A timing error in the master-address field gives NAK at the end of the slave-address field.
- R6: The control code is 4 bits, sent MSB first. Code bit 3 set (a write) while `rx_empty` is 0 gives NAK.
- R7: A read code (3H or 7H) while `tx_empty` is 1 gives NAK.
- R8: While `lock_set` is 1, codes 3H, 6H, 7H, AH, BH, EH and FH give NAK when the master address of the frame differs from `lock_owner`.
- R9: Code 4H gives NAK when `lock_set` is 0. The undefined codes 1H, 2H, 9H, CH and DH always give NAK.
- R10: A NAK sets `abort` on the same edge that raises `ack_valid`. While `abort` is set, no further acknowledge is produced and input is ignored. The `frame_start` strobe clears `abort`.
- R11: While `broadcast` is 1, no acknowledge is driven and `abort` is never set.
- R12: Field widths are 12 bits for each address, 4 for control, and 8 for data length and for each data byte. `field_start` restarts the bit count. Bits that arrive after the parity bit of a field are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe at the start of a frame; clears abort |
| field_start | input | 1 | Strobe at the start of a field |
| field_kind | input | 3 | Field code, sampled with field_start: 0 master address, 1 slave address, 2 control, 3 data length, 4 data |
| bit_valid | input | 1 | A received bit is present |
| bit_val | input | 1 | Value of the received bit |
| timing_err | input | 1 | Bit-format error strobe from the decoder |
| broadcast | input | 1 | Current frame is a broadcast |
| my_addr | input | ADDR_W | Address of this unit |
| rx_empty | input | 1 | Receive buffer is empty |
| tx_empty | input | 1 | Transmit buffer is empty |
| lock_set | input | 1 | Unit is locked |
| lock_owner | input | ADDR_W | Address of the master holding the lock |
| ack_valid | output | 1 | One-cycle pulse: acknowledge decided |
| ack_nak | output | 1 | 0 ACK, 1 NAK; valid with ack_valid |
| abort | output | 1 | Transfer refused; held until frame_start |

## Verification
The parity-bit cycle is where the acknowledge decision is made, and a `timing_err` strobe can land in that same cycle. It can arrive on its own or together with a parity error or a control-code refusal. The bench places timing strobes at random bit positions, including the parity bit itself, and so provokes this overlap. Its reference model gives NAK when any one cause is present, and the bench judges the `ack_nak` and `abort` values seen one cycle later. A second overlap sends a bit straight after a field's parity bit, and the bench checks that it never produces a second acknowledge pulse.

// File: rtl/sbus_ack_pkg.sv
package sbus_ack_pkg;

  typedef enum logic [2:0] {
    FLD_MADR = 3'd0,
    FLD_SADR = 3'd1,
    FLD_CTRL = 3'd2,
    FLD_DLEN = 3'd3,
    FLD_DATA = 3'd4,
    FLD_IDLE = 3'd7
  } fld_e;

  localparam int CODE_W = 4;

  function automatic fld_e fld_decode(input logic [2:0] raw);
    case (raw)
      3'd0:    return FLD_MADR;
      3'd1:    return FLD_SADR;
      3'd2:    return FLD_CTRL;
      3'd3:    return FLD_DLEN;
      3'd4:    return FLD_DATA;
      default: return FLD_IDLE;
    endcase
  endfunction

  function automatic logic fld_has_ack(input fld_e k);
    return (k == FLD_SADR) || (k == FLD_CTRL) || (k == FLD_DLEN) || (k == FLD_DATA);
  endfunction

  function automatic logic code_defined(input logic [CODE_W-1:0] c);
    case (c)
      4'h1, 4'h2, 4'h9, 4'hC, 4'hD: return 1'b0;
      default:                      return 1'b1;
    endcase
  endfunction

  function automatic logic code_lock_guarded(input logic [CODE_W-1:0] c);
    case (c)
      4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

  function automatic logic code_is_read(input logic [CODE_W-1:0] c);
    return (c == 4'h3) || (c == 4'h7);
  endfunction

  function automatic logic code_is_write(input logic [CODE_W-1:0] c);
    return c[CODE_W-1];
  endfunction

  function automatic logic code_is_lockrd(input logic [CODE_W-1:0] c);
    return c == 4'h4;
  endfunction

endpackage

// File: rtl/sbus_field_acc.sv
module sbus_field_acc #(
  parameter int MAXW  = 12,
  parameter int CNT_W = $clog2(MAXW + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] width,
  output logic [MAXW-1:0]  value,
  output logic             last,
  output logic             par_bad
);

  logic [CNT_W-1:0] cnt;
  logic             room;

  assign room    = (cnt <= width);
  assign last    = en && (cnt == width);
  assign par_bad = (^value) ^ bit_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      value <= '0;
    end else if (clear) begin
      cnt   <= '0;
      value <= '0;
    end else if (en && room) begin
      cnt <= cnt + 1'b1;
      if (cnt < width) value <= {value[MAXW-2:0], bit_in};
    end
  end

endmodule

// File: rtl/sbus_ctrl_screen.sv
module sbus_ctrl_screen
  import sbus_ack_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              rx_empty,
  input  logic              tx_empty,
  input  logic              lock_set,
  input  logic              owner_match,
  output logic              refuse
);

  logic bad_undef, bad_write, bad_read, bad_lock, bad_lockrd;

  always_comb begin
    bad_undef  = !code_defined(code);
    bad_write  = code_is_write(code) && !rx_empty;
    bad_read   = code_is_read(code) && tx_empty;
    bad_lock   = lock_set && !owner_match && code_lock_guarded(code);
    bad_lockrd = code_is_lockrd(code) && !lock_set;
    refuse     = bad_undef || bad_write || bad_read || bad_lock || bad_lockrd;
  end

endmodule

// File: rtl/sbus_ack_gen.sv
module sbus_ack_gen
  import sbus_ack_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              field_start,
  input  logic [2:0]        field_kind,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              timing_err,
  input  logic              broadcast,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              rx_empty,
  input  logic              tx_empty,
  input  logic              lock_set,
  input  logic [ADDR_W-1:0] lock_owner,
  output logic              ack_valid,
  output logic              ack_nak,
  output logic              abort
);

  localparam int MAXW  = (ADDR_W > BYTE_W) ? ADDR_W : BYTE_W;
  localparam int CNT_W = $clog2(MAXW + 2);

  fld_e              kind;
  logic              tmg_lat;
  logic              ma_bad;
  logic [ADDR_W-1:0] ma_addr;
  logic              ack_v_q, ack_n_q, abort_q;

  logic              en_bits, acc_clear, field_end, acc_pbad;
  logic [MAXW-1:0]   acc_val;
  logic [CNT_W-1:0]  field_w;
  logic              tmg_any, ctrl_refuse, nak_now, ack_fire;

  assign en_bits   = bit_valid && !field_start && !frame_start && !abort_q && (kind != FLD_IDLE);
  assign acc_clear = field_start || frame_start;
  assign tmg_any   = tmg_lat || (timing_err && en_bits);

  always_comb begin
    case (kind)
      FLD_MADR, FLD_SADR: field_w = CNT_W'(ADDR_W);
      FLD_CTRL:           field_w = CNT_W'(CODE_W);
      FLD_DLEN, FLD_DATA: field_w = CNT_W'(BYTE_W);
      default:            field_w = '0;
    endcase
  end

  sbus_field_acc #(.MAXW(MAXW), .CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (acc_clear),
    .en      (en_bits),
    .bit_in  (bit_val),
    .width   (field_w),
    .value   (acc_val),
    .last    (field_end),
    .par_bad (acc_pbad)
  );

  sbus_ctrl_screen u_screen (
    .code        (acc_val[CODE_W-1:0]),
    .rx_empty    (rx_empty),
    .tx_empty    (tx_empty),
    .lock_set    (lock_set),
    .owner_match (ma_addr == lock_owner),
    .refuse      (ctrl_refuse)
  );

  always_comb begin
    nak_now = acc_pbad || tmg_any;
    case (kind)
      FLD_SADR: nak_now = nak_now || ma_bad || (acc_val[ADDR_W-1:0] != my_addr);
      FLD_CTRL: nak_now = nak_now || ctrl_refuse;
      default:  ;
    endcase
  end

  assign ack_fire = field_end && fld_has_ack(kind) && !broadcast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind    <= FLD_IDLE;
      tmg_lat <= 1'b0;
      ma_bad  <= 1'b0;
      ma_addr <= '0;
      ack_v_q <= 1'b0;
      ack_n_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      ack_v_q <= ack_fire;
      ack_n_q <= ack_fire && nak_now;
      if (frame_start) begin
        kind    <= FLD_IDLE;
        tmg_lat <= 1'b0;
        ma_bad  <= 1'b0;
        abort_q <= 1'b0;
      end else begin
        if (ack_fire && nak_now) abort_q <= 1'b1;
        if (field_start) begin
          kind    <= abort_q ? FLD_IDLE : fld_decode(field_kind);
          tmg_lat <= 1'b0;
        end else if (timing_err && en_bits) begin
          tmg_lat <= 1'b1;
        end
        if (field_end && kind == FLD_MADR) begin
          ma_bad  <= acc_pbad || tmg_any;
          ma_addr <= acc_val[ADDR_W-1:0];
        end
      end
    end
  end

  assign ack_valid = ack_v_q;
  assign ack_nak   = ack_n_q;
  assign abort     = abort_q;

endmodule

// File: rtl/sbus_ack_chk.sv
module sbus_ack_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic bit_valid,
  input logic broadcast,
  input logic field_end,
  input logic nak_now,
  input logic ack_valid,
  input logic ack_nak,
  input logic abort
);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);

  a_r3_follows_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($past(field_end) && $past(bit_valid)));

  a_r3_nak_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> !ack_nak);

  a_r3_nak_matches_decision: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_nak == $past(nak_now)));

  a_r10_nak_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_nak) |-> abort);

  a_r10_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !frame_start) |=> abort);

  a_r10_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !abort);

  a_r10_quiet_when_aborted: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !$past(abort));

  a_r11_bcast_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !$past(broadcast));

  a_r11_bcast_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> !$past(broadcast));

endmodule

bind sbus_ack_gen sbus_ack_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .bit_valid   (bit_valid),
  .broadcast   (broadcast),
  .field_end   (field_end),
  .nak_now     (nak_now),
  .ack_valid   (ack_valid),
  .ack_nak     (ack_nak),
  .abort       (abort)
);

// File: tb/test_sbus_ack_gen.sv
module test_sbus_ack_gen;

  localparam logic [11:0] MY = 12'h5A3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, field_start = 0, bit_valid = 0, bit_val = 0, timing_err = 0;
  logic [2:0] field_kind = 0;
  logic broadcast = 0, rx_empty = 1, tx_empty = 0, lock_set = 0;
  logic [11:0] my_addr = MY;
  logic [11:0] lock_owner = 0;
  logic ack_valid, ack_nak, abort;

  int tests = 0, fails = 0;
  logic got_v, got_b, got_a, got_v2;

  always #2.5 clk = ~clk;

  sbus_ack_gen i_sbus_ack_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .field_start(field_start),
    .field_kind(field_kind), .bit_valid(bit_valid), .bit_val(bit_val),
    .timing_err(timing_err), .broadcast(broadcast), .my_addr(my_addr),
    .rx_empty(rx_empty), .tx_empty(tx_empty), .lock_set(lock_set),
    .lock_owner(lock_owner), .ack_valid(ack_valid), .ack_nak(ack_nak), .abort(abort)
  );

  task automatic chk(input string tag, input logic got, input logic exp, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  function automatic bit tb_ones_odd(input logic [11:0] v, input int w);
    int n = 0;
    for (int i = 0; i < w; i++) n += int'(v[i]);
    return n % 2 == 1;
  endfunction

  // control-code model: returns requirement tag of first refusal reason, "" if accepted
  function automatic string tb_ctrl_reason(input logic [3:0] c, input logic rxe, input logic txe,
                                           input logic lk, input logic own);
    logic [15:0] undef_set = 16'h3206;
    logic [15:0] guard_set = 16'hCCC8;
    if (undef_set[c]) return "R9";
    if (c[3] && !rxe) return "R6";
    if ((c == 4'h3 || c == 4'h7) && txe) return "R7";
    if (lk && !own && guard_set[c]) return "R8";
    if (c == 4'h4 && !lk) return "R9";
    return "";
  endfunction

  task automatic start_frame();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    chk("R10", abort, 1'b0, "abort after frame_start");
  endtask

  task automatic send_field(input logic [2:0] k, input logic [11:0] v, input int w,
                            input logic badpar, input logic tmg, input logic xb);
    int tpos = $urandom_range(0, w);
    @(negedge clk); field_start = 1; field_kind = k; bit_valid = 0;
    for (int i = 0; i <= w; i++) begin
      @(negedge clk);
      field_start = 0;
      bit_valid   = 1;
      bit_val     = (i < w) ? v[w-1-i] : (tb_ones_odd(v, w) ^ badpar);
      timing_err  = tmg && (i == tpos);
    end
    @(negedge clk); bit_valid = 0; timing_err = 0;
    got_v = ack_valid; got_b = ack_nak; got_a = abort;
    if (xb) begin bit_valid = 1; bit_val = 1; end
    @(negedge clk); got_v2 = ack_valid; bit_valid = 0;
    @(negedge clk); got_v2 = got_v2 | ack_valid;
  endtask

  task automatic do_frame(input logic [11:0] ma, input logic [11:0] sa, input logic [3:0] cc,
                          input int nb, input logic bc, input logic [5:0] bp,
                          input logic [5:0] te, input logic xb);
    logic ab = 0, mbad = 0, nk;
    string tg, mtg = "", cr;
    logic [11:0] v; int w; logic [2:0] k;
    start_frame();
    broadcast = bc;
    for (int f = 0; f < 4 + nb; f++) begin
      case (f)
        0: begin k = 0; v = ma; w = 12; end
        1: begin k = 1; v = sa; w = 12; end
        2: begin k = 2; v = {8'h0, cc}; w = 4; end
        3: begin k = 3; v = 12'(nb); w = 8; end
        default: begin k = 4; v = 12'($urandom_range(0, 255)); w = 8; end
      endcase
      send_field(k, v, w, bp[f], te[f], xb);
      if (ab) begin
        chk("R10", got_v, 1'b0, "ack while aborted");
        chk("R10", got_a, 1'b1, "abort held");
      end else begin
        nk = bp[f] | te[f];
        tg = bp[f] ? "R2" : (te[f] ? "R5" : "R3");
        if (f == 0) begin
          mbad = nk; mtg = tg;
          chk("R3", got_v, 1'b0, "no ack after master address");
          chk("R3", got_a, 1'b0, "no abort after master address");
        end else begin
          if (f == 1 && !nk && mbad) begin nk = 1; tg = mtg; end
          if (f == 1 && !nk && sa != MY) begin nk = 1; tg = "R4"; end
          if (f == 2 && !nk) begin
            cr = tb_ctrl_reason(cc, rx_empty, tx_empty, lock_set, ma == lock_owner);
            if (cr != "") begin nk = 1; tg = cr; end
          end
          if (bc) begin
            chk("R11", got_v, 1'b0, "broadcast ack");
            chk("R11", got_a, 1'b0, "broadcast abort");
          end else begin
            chk("R3", got_v, 1'b1, "ack pulse");
            chk(tg, got_b, nk, "ack_nak");
            chk("R10", got_a, nk, "abort with nak");
            ab = nk;
          end
        end
      end
      chk(xb ? "R12" : "R3", got_v2, 1'b0, "second ack pulse");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", ack_valid, 1'b0, "reset ack_valid");
    chk("R1", ack_nak, 1'b0, "reset ack_nak");
    chk("R1", abort, 1'b0, "reset abort");

    // directed
    rx_empty = 1; tx_empty = 0; lock_set = 0; lock_owner = 12'h123;
    do_frame(12'h123, MY, 4'h3, 2, 0, 6'h00, 6'h00, 0);   // R3 all ACK
    do_frame(12'h123, MY, 4'h8, 1, 0, 6'h00, 6'h00, 1);   // R12 extra bits
    rx_empty = 0;
    do_frame(12'h123, MY, 4'hA, 1, 0, 6'h00, 6'h00, 0);   // R6 write, rx full
    rx_empty = 1; tx_empty = 1;
    do_frame(12'h123, MY, 4'h7, 1, 0, 6'h00, 6'h00, 0);   // R7 read, tx empty
    tx_empty = 0; lock_set = 1; lock_owner = 12'h777;
    do_frame(12'h123, MY, 4'h6, 1, 0, 6'h00, 6'h00, 0);   // R8 foreign master
    do_frame(12'h777, MY, 4'h6, 1, 0, 6'h00, 6'h00, 0);   // R8 owner accepted
    do_frame(12'h123, MY, 4'h4, 1, 0, 6'h00, 6'h00, 0);   // R9 lock read with lock
    lock_set = 0;
    do_frame(12'h123, MY, 4'h4, 1, 0, 6'h00, 6'h00, 0);   // R9 lock read no lock
    do_frame(12'h123, MY, 4'hC, 1, 0, 6'h00, 6'h00, 0);   // R9 undefined
    do_frame(12'h123, 12'h5A2, 4'h0, 1, 0, 6'h00, 6'h00, 0); // R4 mismatch
    do_frame(12'h123, MY, 4'h0, 1, 1, 6'h02, 6'h00, 0);   // R11 broadcast, bad parity
    do_frame(12'h123, MY, 4'h0, 1, 0, 6'h00, 6'h04, 0);   // R5 timing on control
    do_frame(12'h123, MY, 4'h0, 1, 0, 6'h01, 6'h00, 0);   // R2 master parity
    do_frame(12'h123, MY, 4'h0, 1, 0, 6'h00, 6'h01, 0);   // R5 master timing
    do_frame(12'h123, MY, 4'h0, 2, 0, 6'h20, 6'h00, 0);   // R2 data parity

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [11:0] ma = 12'($urandom);
      logic [5:0] bp = 0, te = 0;
      for (int b = 0; b < 6; b++) begin
        bp[b] = ($urandom_range(0, 11) == 0);
        te[b] = ($urandom_range(0, 11) == 0);
      end
      rx_empty   = 1'($urandom);
      tx_empty   = 1'($urandom);
      lock_set   = 1'($urandom);
      lock_owner = $urandom_range(0, 1) ? ma : 12'($urandom);
      do_frame(ma, $urandom_range(0, 3) != 0 ? MY : 12'($urandom), 4'($urandom),
               $urandom_range(1, 2), $urandom_range(0, 4) == 0, bp, te,
               $urandom_range(0, 7) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule